// File: doc/BRIEF.md
# Dynamic 32/16-bit Bus Width Adapter

This block converts word-wide transfer requests from a 32-bit processor bus interface into bus cycles for a port whose width is chosen per cycle: 32 or 16 bits. A request carries a word address, four active-low byte enables, a direction flag and 32-bit write data. The block drives one bus cycle with those values. It also drives three extra 16-bit addressing signals, which are derived from the enables: a low-half byte strobe, a high-half byte strobe and address bit 1.

The port answers with a ready signal and an active-low width indication. The block samples the width indication only on the edge where ready is high. The write data has to be valid before the block knows the width. For this reason, when only the upper half of the word is enabled, the upper 16 bits of write data are always copied onto the lower lanes.

A 16-bit answer to a request that enables bytes in both halves triggers a second bus cycle. In that cycle the lower two enables are off. Read data that comes back on the low lanes is moved into the upper half of the returned word. A single `done` pulse marks the end of each request.

Top module: `bus_sizer`

## Requirements
- R1: `bus_a1` is 1 exactly when enables 0 and 1 (`bus_be_n[1:0]`) are both inactive (2'b11) during a bus cycle.
- R2: `bus_ble_n` is low when byte 0 is enabled, or when byte 2 is enabled and `bus_a1` is 1. `bus_bhe_n` is low when byte 1 is enabled, or when byte 3 is enabled and `bus_a1` is 1.
- R3: On a write whose lower two enables are inactive, `bus_wdata[15:0]` equals `bus_wdata[31:16]` for the whole cycle. This holds for either width answer.
- R4: If `bus_bs16_n` is high on the ready edge, the request ends after one cycle and the returned data equals `bus_rdata` unchanged.
- R5: A low `bus_bs16_n` on a cycle whose upper two enables are inactive has no effect: the request ends after one cycle and returns `bus_rdata` unchanged.
- R6: A 16-bit answer to a read that enables only upper bytes returns `{bus_rdata[15:0], bus_rdata[15:0]}`.
- R7: A 16-bit answer to a request that enables bytes in both halves starts a second cycle on the next clock. That cycle has the same address and direction, the upper enables unchanged, and `bus_be_n[1:0]` = 2'b11.
- R8: In the second cycle the write data's lower half is the request's upper half. A split read returns `{second bus_rdata[15:0], first bus_rdata[15:0]}`.
- R9: `done` is high for exactly one clock, in the cycle after the last ready edge, and `bus_cyc` is then low.
- R10: While `bus_ready` is low, a bus cycle keeps its address and enables, and `bus_bs16_n` is ignored.
- R11: After reset the block is idle: `bus_cyc` = 0, `bus_be_n` = 4'hF and `done` = 0. A `req_valid` that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | ADDR_W-2 | Word address |
| req_be_n | input | 4 | Active-low byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Realigned read data, valid with `done` |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | ADDR_W-2 | Word address on the bus |
| bus_be_n | output | 4 | Active-low byte enables on the bus |
| bus_a1 | output | 1 | Address bit 1 for 16-bit ports |
| bus_ble_n | output | 1 | Active-low low-byte strobe for 16-bit ports |
| bus_bhe_n | output | 1 | Active-low high-byte strobe for 16-bit ports |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the port |
| bus_ready | input | 1 | Cycle completes on this edge |
| bus_bs16_n | input | 1 | Active-low 16-bit width answer, sampled with ready |

## Verification
Every legal contiguous enable pattern is tried: lower only, upper only, and straddling both halves. Each pattern meets both width answers, so single-cycle, folded and split outcomes are told apart. Wait states carry a toggling width input, which shows that the block samples it only on the ready edge. A request raised while the block is busy shows that such requests are dropped. Split reads use different data in each cycle, so a swapped half or a stale holding register shows up in the returned word.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } bsz_state_t;
endpackage

// File: rtl/bsz_addr_gen.sv
module bsz_addr_gen
  import bsz_pkg::*;
(
  input  logic [BE_W-1:0] be_n,
  output logic            a1,
  output logic            ble_n,
  output logic            bhe_n
);
  logic lo_off;

  always_comb begin
    lo_off = &be_n[1:0];
    a1     = lo_off;
    ble_n  = ~(~be_n[0] | (lo_off & ~be_n[2]));
    bhe_n  = ~(~be_n[1] | (lo_off & ~be_n[3]));
  end
endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  logic [BE_W-1:0]   be_n,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    dout = din;
    if ((&be_n[1:0]) && !(&be_n[3:2]))
      dout[HALF_W-1:0] = din[DATA_W-1:HALF_W];
  end
endmodule

// File: rtl/bsz_rd_align.sv
module bsz_rd_align
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] bus_d,
  input  logic [HALF_W-1:0] low_hold,
  input  logic              fold,
  input  logic              join_hold,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    if (join_hold)
      dout = {bus_d[HALF_W-1:0], low_hold};
    else if (fold)
      dout = {bus_d[HALF_W-1:0], bus_d[HALF_W-1:0]};
    else
      dout = bus_d;
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:2]     req_addr,
  input  logic [BE_W-1:0]       req_be_n,
  input  logic                  req_write,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  done,
  output logic [DATA_W-1:0]     rdata,
  output logic                  bus_cyc,
  output logic [ADDR_W-1:2]     bus_addr,
  output logic [BE_W-1:0]       bus_be_n,
  output logic                  bus_a1,
  output logic                  bus_ble_n,
  output logic                  bus_bhe_n,
  output logic                  bus_write,
  output logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     bus_rdata,
  input  logic                  bus_ready,
  input  logic                  bus_bs16_n
);
  localparam logic [BE_W-1:0] BE_NONE = '1;

  bsz_state_t        st, st_next;
  logic [BE_W-1:0]   be_next;
  logic              lo_used, hi_used, narrow;
  logic              need_split, fold_rd;
  logic [HALF_W-1:0] low_hold;
  logic [DATA_W-1:0] steer_in, steer_out, align_out;
  logic              a1_next, ble_next, bhe_next;

  always_comb begin
    lo_used    = !(&bus_be_n[1:0]);
    hi_used    = !(&bus_be_n[3:2]);
    narrow     = !bus_bs16_n;
    need_split = narrow && lo_used && hi_used;
    fold_rd    = narrow && !lo_used && hi_used;
  end

  always_comb begin
    st_next = st;
    be_next = bus_be_n;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          st_next = ST_FIRST;
          be_next = req_be_n;
        end
      end
      ST_FIRST: begin
        if (bus_ready) begin
          if (need_split) begin
            st_next = ST_SECOND;
            be_next = {bus_be_n[3:2], 2'b11};
          end else begin
            st_next = ST_IDLE;
            be_next = BE_NONE;
          end
        end
      end
      ST_SECOND: begin
        if (bus_ready) begin
          st_next = ST_IDLE;
          be_next = BE_NONE;
        end
      end
      default: begin
        st_next = ST_IDLE;
        be_next = BE_NONE;
      end
    endcase
  end

  assign steer_in = (st == ST_IDLE) ? req_wdata : bus_wdata;

  bsz_wr_steer u_steer (
    .din  (steer_in),
    .be_n (be_next),
    .dout (steer_out)
  );

  bsz_addr_gen u_agen (
    .be_n  (be_next),
    .a1    (a1_next),
    .ble_n (ble_next),
    .bhe_n (bhe_next)
  );

  bsz_rd_align u_align (
    .bus_d     (bus_rdata),
    .low_hold  (low_hold),
    .fold      (fold_rd),
    .join_hold (st == ST_SECOND),
    .dout      (align_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bus_cyc   <= 1'b0;
      bus_be_n  <= BE_NONE;
      bus_a1    <= 1'b0;
      bus_ble_n <= 1'b1;
      bus_bhe_n <= 1'b1;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      low_hold  <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      st        <= st_next;
      bus_cyc   <= (st_next != ST_IDLE);
      bus_be_n  <= be_next;
      bus_a1    <= (st_next != ST_IDLE) && a1_next;
      bus_ble_n <= (st_next == ST_IDLE) || ble_next;
      bus_bhe_n <= (st_next == ST_IDLE) || bhe_next;
      bus_wdata <= steer_out;
      done      <= 1'b0;
      if (st == ST_IDLE && req_valid) begin
        bus_addr  <= req_addr;
        bus_write <= req_write;
      end
      if (st == ST_FIRST && bus_ready && need_split)
        low_hold <= bus_rdata[HALF_W-1:0];
      if (st != ST_IDLE && st_next == ST_IDLE) begin
        done  <= 1'b1;
        rdata <= align_out;
      end
    end
  end
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              bus_cyc,
  input logic [ADDR_W-1:2] bus_addr,
  input logic [BE_W-1:0]   bus_be_n,
  input logic              bus_a1,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready
);
  AST_A1_FOLLOWS_LOW_ENABLES: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> (bus_a1 == (&bus_be_n[1:0]))); // R1

  AST_UPPER_ONLY_WRITE_DUP: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_write && (&bus_be_n[1:0])) |->
      (bus_wdata[HALF_W-1:0] == bus_wdata[DATA_W-1:HALF_W])); // R3

  AST_NEXT_CYCLE_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && $past(bus_cyc) && $past(bus_ready)) |->
      ((bus_be_n[1:0] == 2'b11) && (bus_addr == $past(bus_addr)))); // R7

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_cyc && $past(bus_cyc) && $past(bus_ready))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_WAIT_HOLDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_be_n) && $stable(bus_addr))); // R10

  AST_IDLE_NO_ENABLES: assert property (@(posedge clk) disable iff (rst)
    !bus_cyc |-> (bus_be_n == 4'hF)); // R11
endmodule

bind bus_sizer bus_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .bus_cyc   (bus_cyc),
  .bus_addr  (bus_addr),
  .bus_be_n  (bus_be_n),
  .bus_a1    (bus_a1),
  .bus_write (bus_write),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready)
);

// File: tb/test_bus_sizer.sv
module test_bus_sizer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:2] req_addr = '0;
  logic [3:0]  req_be_n = 4'hF;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic        bus_cyc;
  logic [31:2] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_a1, bus_ble_n, bus_bhe_n, bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        bus_bs16_n = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bus_sizer i_bus_sizer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_be_n(req_be_n), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_a1(bus_a1), .bus_ble_n(bus_ble_n),
    .bus_bhe_n(bus_bhe_n), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_bs16_n(bus_bs16_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] legal_be_n(input int k);
    case (k)
      0: return 4'b1110;  1: return 4'b1101;  2: return 4'b1011;
      3: return 4'b0111;  4: return 4'b1100;  5: return 4'b1001;
      6: return 4'b0011;  7: return 4'b1000;  8: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic exp_a1(input logic [3:0] b);
    return b[1] && b[0];
  endfunction
  function automatic logic exp_ble_n(input logic [3:0] b);
    return !(!b[0] || (exp_a1(b) && !b[2]));
  endfunction
  function automatic logic exp_bhe_n(input logic [3:0] b);
    return !(!b[1] || (exp_a1(b) && !b[3]));
  endfunction
  function automatic logic [31:0] exp_wd(input logic [3:0] b, input logic [31:0] d);
    if (b[1:0] == 2'b11 && b[3:2] != 2'b11) return {d[31:16], d[31:16]};
    return d;
  endfunction
  function automatic logic is_split(input logic [3:0] b, input logic s16n);
    return !s16n && (b[1:0] != 2'b11) && (b[3:2] != 2'b11);
  endfunction
  function automatic logic [31:0] exp_rd(input logic [3:0] b, input logic s16n,
                                         input logic [31:0] r1, input logic [31:0] r2);
    if (is_split(b, s16n)) return {r2[15:0], r1[15:0]};
    if (!s16n && b[1:0] == 2'b11) return {r1[15:0], r1[15:0]};
    return r1;
  endfunction

  task automatic check_cycle(input string tag, input logic [3:0] b, input logic [29:0] a,
                             input logic we, input logic [31:0] wd);
    check({tag, " R1 a1"}, 64'(bus_a1), 64'(exp_a1(b)));
    check({tag, " R2 ble"}, 64'(bus_ble_n), 64'(exp_ble_n(b)));
    check({tag, " R2 bhe"}, 64'(bus_bhe_n), 64'(exp_bhe_n(b)));
    check({tag, " R7 be"}, 64'(bus_be_n), 64'(b));
    check({tag, " R7 addr"}, 64'(bus_addr), 64'(a));
    check({tag, " R7 dir"}, 64'(bus_write), 64'(we));
    if (we) check({tag, " R3 R8 wdata"}, 64'(bus_wdata), 64'(exp_wd(b, wd)));
  endtask

  task automatic run_req(input logic [3:0] b, input logic we, input logic [31:0] wd,
                         input logic s16n, input int waits, input logic poke);
    logic [29:0] a = 30'($urandom);
    logic [31:0] r1 = $urandom;
    logic [31:0] r2 = $urandom;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_be_n = b; req_write = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 cyc start", 64'(bus_cyc), 64'd1);
    check_cycle("c1", b, a, we, wd);
    for (int w = 0; w < waits; w++) begin
      bus_ready = 1'b0; bus_bs16_n = ~bus_bs16_n; bus_rdata = $urandom;
      if (poke) begin
        req_valid = 1'b1; req_be_n = ~b; req_addr = ~a;
      end
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 wait hold be", 64'(bus_be_n), 64'(b));
      check("R10 R11 wait addr", 64'(bus_addr), 64'(a));
      check("R10 no done", 64'(done), 64'd0);
    end
    bus_ready = 1'b1; bus_bs16_n = s16n; bus_rdata = r1;
    @(negedge clk);
    if (is_split(b, s16n)) begin
      check("R7 second cyc", 64'(bus_cyc), 64'd1);
      check("R9 no early done", 64'(done), 64'd0);
      check_cycle("c2", {b[3:2], 2'b11}, a, we, {wd[31:16], wd[31:16]});
      bus_ready = 1'b1; bus_bs16_n = 1'($urandom); bus_rdata = r2;
      @(negedge clk);
    end
    bus_ready = 1'b0; bus_bs16_n = 1'b1;
    check("R9 done", 64'(done), 64'd1);
    check("R9 cyc end", 64'(bus_cyc), 64'd0);
    if (!we) check("R4 R5 R6 R8 rdata", 64'(rdata), 64'(exp_rd(b, s16n, r1, r2)));
    @(negedge clk);
    check("R9 R11 done single", 64'(done), 64'd0);
    check("R11 idle after", 64'(bus_cyc), 64'd0);
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset cyc", 64'(bus_cyc), 64'd0);
        check("R11 reset be", 64'(bus_be_n), 64'hF);
        check("R11 reset done", 64'(done), 64'd0);
        for (int k = 0; k < 10; k++) begin
          run_req(legal_be_n(k), 1'b0, $urandom, 1'b0, 0, 1'b0);
          run_req(legal_be_n(k), 1'b0, $urandom, 1'b1, 1, 1'b0);
          run_req(legal_be_n(k), 1'b1, $urandom, 1'b0, 0, 1'b0);
          run_req(legal_be_n(k), 1'b1, $urandom, 1'b1, 0, 1'b0);
        end
        run_req(4'b0000, 1'b0, 32'h0, 1'b0, 3, 1'b1);
        run_req(4'b1100, 1'b1, 32'hA5A5_3C3C, 1'b0, 2, 1'b1);
        for (int i = 0; i < 300; i++)
          run_req(legal_be_n(int'($urandom_range(0, 9))), 1'($urandom), $urandom,
                  1'($urandom), int'($urandom_range(0, 3)), 1'($urandom));
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule